// File: doc/BRIEF.md
# LDPC Hard-Decision Slicer and Parity Syndrome Checker

This block sits at the end of each iteration of an iterative LDPC decoder. It receives one signed soft total per code bit, decides each bit from the sign of that total, and then tests the decided word against every parity equation of a fixed parity-check matrix. It reports the decided word, the per-row parity results, how many equations failed, and a single stop flag that tells the iteration controller whether the word is already a valid codeword. The controller uses the stop flag to end decoding early.

The matrix, code length, row count and soft-value width are elaboration-time parameters. The matrix is held as a packed constant, one row of `CODE_LEN` bits per parity equation. Computing the soft totals and deciding when to start a new iteration are left to the surrounding decoder. All results are registered. They change only in the cycle after a valid strobe and are held otherwise.

Top module: `ldpc_syndrome_check`

## Requirements
- R1: The decided bit for column j (bit j of `hardWord`, soft value in `softIn[j*SOFT_W +: SOFT_W]`, two's complement) is 1 when that value is negative. It is 0 when the value is zero or positive, following the symbol mapping 1-2X.
- R2: Syndrome bit r is the XOR of the decided bits in every column j where bit j of row r (`H_MATRIX[r*CODE_LEN +: CODE_LEN]`) is 1. The default rows r0..r5 are 12'h28C, 12'h033, 12'hD40, 12'h0AA, 12'h941 and 12'h614.
- R3: `failCount` equals the number of syndrome bits that are 1. Its width is ceil(log2(NUM_ROWS+1)).
- R4: `stopIter` is 1 when `failCount` is zero and 0 when it is nonzero, for every result that is presented.
- R5: All outputs are registered. A result appears in the clock cycle after `validIn` is sampled high, and `validOut` is high for exactly that one cycle per accepted input.
- R6: When `validIn` is low, `softIn` is ignored and every result output keeps its previous value.
- R7: After reset, `hardWord`, `syndrome`, `failCount`, `stopIter` and `validOut` are all zero.
- R8: With the default matrix, the soft inputs -91 49 -32 36 -14 31 3 16 -61 -25 -78 -68 (columns 0..11) give `hardWord` 12'hF15, `syndrome` 6'h14, a fail count of 2 and `stopIter` 0. Changing column 6 to -42 gives 12'hF55, a fail count of 0 and `stopIter` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Soft vector is present this cycle |
| softIn | input | CODE_LEN*SOFT_W | Signed soft totals, column j at bits j*SOFT_W upward |
| validOut | output | 1 | Results updated this cycle |
| hardWord | output | CODE_LEN | Decided bits, bit j is column j |
| syndrome | output | NUM_ROWS | Per-row parity failure bits |
| failCount | output | FAIL_W | Number of failing rows |
| stopIter | output | 1 | 1: valid codeword, stop; 0: run another iteration |

## Verification
Capturing a new soft vector and presenting the result of the previous one happen in the same clock edge whenever vectors arrive back to back. This is the normal case for an iterating decoder. The bench drives all 4096 decided-word patterns on consecutive cycles with varied magnitudes, including zero and the most negative value. On each cycle it compares the presented word, syndrome, count and stop flag against values computed arithmetically for the vector of the previous cycle, while the next vector is already on the inputs. After the stream ends, it changes the inputs with the strobe low and checks that the last result is held.

// File: rtl/ldpc_syn_pkg.sv
package ldpc_syn_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;   // load new decision and syndrome results
    logic present;   // a result is being presented this cycle
  } synStrobe_t;

  function automatic int unsigned failWidth(input int unsigned rows);
    return $clog2(rows + 1);
  endfunction

endpackage

// File: rtl/ldpc_syn_ctrl.sv
module ldpc_syn_ctrl
  import ldpc_syn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  output synStrobe_t strobe,
  output logic       validOut
);

  logic presentQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presentQ <= 1'b0;
    else       presentQ <= validIn;
  end

  always_comb begin
    strobe.capture = validIn;
    strobe.present = presentQ;
  end

  assign validOut = presentQ;

  // R5: one-cycle latency of the valid strobe
  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

endmodule

// File: rtl/ldpc_syn_datapath.sv
module ldpc_syn_datapath
  import ldpc_syn_pkg::*;
#(
  parameter int unsigned CODE_LEN = 12,
  parameter int unsigned NUM_ROWS = 6,
  parameter int unsigned SOFT_W   = 8,
  parameter logic [NUM_ROWS*CODE_LEN-1:0] H_MATRIX = '0,
  localparam int unsigned FAIL_W  = failWidth(NUM_ROWS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  synStrobe_t                 strobe,
  input  logic [CODE_LEN*SOFT_W-1:0] softIn,
  output logic [CODE_LEN-1:0]        hardWord,
  output logic [NUM_ROWS-1:0]        syndrome,
  output logic [FAIL_W-1:0]          failCount,
  output logic                       stopIter
);

  logic [CODE_LEN-1:0] hardNext;
  logic [NUM_ROWS-1:0] synNext;
  logic [FAIL_W-1:0]   countNext;

  // Sign slicer: negative total decides 1, zero or positive decides 0
  for (genvar j = 0; j < CODE_LEN; j++) begin : g_slice
    assign hardNext[j] = softIn[j*SOFT_W + SOFT_W - 1];
  end

  // One parity equation per matrix row
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    localparam logic [CODE_LEN-1:0] ROW_MASK = H_MATRIX[r*CODE_LEN +: CODE_LEN];
    assign synNext[r] = ^(hardNext & ROW_MASK);
  end

  always_comb begin
    countNext = '0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      countNext = countNext + FAIL_W'(synNext[r]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hardWord  <= '0;
      syndrome  <= '0;
      failCount <= '0;
      stopIter  <= 1'b0;
    end else if (strobe.capture) begin
      hardWord  <= hardNext;
      syndrome  <= synNext;
      failCount <= countNext;
      stopIter  <= (synNext == '0);
    end
  end

  // R3: registered count agrees with registered syndrome
  assert_count_matches_R3: assert property (@(posedge clk) disable iff (!rstN)
    failCount == FAIL_W'($countones(syndrome)));
  // R6: results are held without a capture strobe
  assert_hold_results_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(hardWord) && $stable(syndrome) && $stable(stopIter)));

endmodule

// File: rtl/ldpc_syndrome_check.sv
module ldpc_syndrome_check
  import ldpc_syn_pkg::*;
#(
  parameter int unsigned CODE_LEN = 12,
  parameter int unsigned NUM_ROWS = 6,
  parameter int unsigned SOFT_W   = 8,
  parameter logic [NUM_ROWS*CODE_LEN-1:0] H_MATRIX =
    {12'h614, 12'h941, 12'h0AA, 12'hD40, 12'h033, 12'h28C},
  localparam int unsigned FAIL_W  = failWidth(NUM_ROWS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       validIn,
  input  logic [CODE_LEN*SOFT_W-1:0] softIn,
  output logic                       validOut,
  output logic [CODE_LEN-1:0]        hardWord,
  output logic [NUM_ROWS-1:0]        syndrome,
  output logic [FAIL_W-1:0]          failCount,
  output logic                       stopIter
);

  synStrobe_t strobe;

  ldpc_syn_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  ldpc_syn_datapath #(
    .CODE_LEN (CODE_LEN),
    .NUM_ROWS (NUM_ROWS),
    .SOFT_W   (SOFT_W),
    .H_MATRIX (H_MATRIX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .softIn    (softIn),
    .hardWord  (hardWord),
    .syndrome  (syndrome),
    .failCount (failCount),
    .stopIter  (stopIter)
  );

  // R4: stop flag agrees with the count on every presented result
  assert_stop_vs_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.present |-> (stopIter == (failCount == '0)));
  // R2: a zero syndrome never coexists with a nonzero count
  assert_zero_syndrome_R2: assert property (@(posedge clk) disable iff (!rstN)
    (syndrome == '0) |-> (failCount == '0));

endmodule

// File: tb/ldpc_syndrome_check_bench.sv
module ldpc_syndrome_check_bench;

  localparam int N  = 12;
  localparam int M  = 6;
  localparam int W  = 8;
  localparam int FW = 3;
  localparam logic [M*N-1:0] HM =
    {12'h614, 12'h941, 12'h0AA, 12'hD40, 12'h033, 12'h28C};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic [N*W-1:0] softIn = '0;
  logic validOut;
  logic [N-1:0] hardWord;
  logic [M-1:0] syndrome;
  logic [FW-1:0] failCount;
  logic stopIter;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ldpc_syndrome_check u_ldpc_syndrome_check (
    .clk(clk), .rstN(rstN), .validIn(validIn), .softIn(softIn),
    .validOut(validOut), .hardWord(hardWord), .syndrome(syndrome),
    .failCount(failCount), .stopIter(stopIter)
  );

  task automatic expectVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [M-1:0] synOf(input logic [N-1:0] w);
    logic [M-1:0] s;
    for (int r = 0; r < M; r++) s[r] = ^(w & HM[r*N +: N]);
    return s;
  endfunction

  function automatic int popc(input logic [M-1:0] s);
    int c = 0;
    for (int r = 0; r < M; r++) c += int'(s[r]);
    return c;
  endfunction

  task automatic checkOut(input logic [N-1:0] w, input bit vExp);
    logic [M-1:0] s;
    int c;
    s = synOf(w);
    c = popc(s);
    expectVal("R1 hard word", int'(hardWord), int'(w));
    expectVal("R2 syndrome", int'(syndrome), int'(s));
    expectVal("R3 fail count", int'(failCount), c);
    expectVal("R4 stop flag", int'(stopIter), (c == 0) ? 1 : 0);
    expectVal("R5 valid out", int'(validOut), int'(vExp));
  endtask

  // Soft vector whose sign pattern encodes w, with varied magnitudes
  task automatic driveWord(input logic [N-1:0] w, input int k);
    for (int j = 0; j < N; j++) begin
      int v;
      if (w[j]) begin
        v = ((k + j) % 50 == 0) ? -128 : -(1 + ((k*7 + j*13) % 127));
      end else begin
        v = (k*5 + j*3) % 128;
      end
      softIn[j*W +: W] = W'(v);
    end
  endtask

  task automatic driveList(input int vals[N]);
    for (int j = 0; j < N; j++) softIn[j*W +: W] = W'(vals[j]);
  endtask

  initial begin
    int refVals[N];
    logic [N-1:0] prevW;
    repeat (3) @(negedge clk);
    // R7: reset state
    expectVal("R7 reset hard word", int'(hardWord), 0);
    expectVal("R7 reset syndrome", int'(syndrome), 0);
    expectVal("R7 reset count", int'(failCount), 0);
    expectVal("R7 reset stop", int'(stopIter), 0);
    expectVal("R7 reset valid", int'(validOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    expectVal("R7 idle after reset", int'(hardWord), 0);

    // R8: reference vector, two failing rows
    refVals = '{-91, 49, -32, 36, -14, 31, 3, 16, -61, -25, -78, -68};
    driveList(refVals);
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    expectVal("R8 word", int'(hardWord), 'hF15);
    expectVal("R8 syndrome", int'(syndrome), 'h14);
    expectVal("R8 count", int'(failCount), 2);
    expectVal("R8 stop", int'(stopIter), 0);
    expectVal("R8 valid", int'(validOut), 1);

    // R8: corrected word passes every row
    refVals[6] = -42;
    driveList(refVals);
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    expectVal("R8 corrected word", int'(hardWord), 'hF55);
    expectVal("R8 corrected count", int'(failCount), 0);
    expectVal("R8 corrected stop", int'(stopIter), 1);

    // R6: inputs change with strobe low, results held
    driveWord(12'h0FF, 3);
    @(negedge clk);
    expectVal("R6 held word", int'(hardWord), 'hF55);
    expectVal("R6 held stop", int'(stopIter), 1);
    expectVal("R6 valid low", int'(validOut), 0);
    driveWord(12'hA5A, 9);
    @(negedge clk);
    checkOut(12'hF55, 1'b0);

    // Back-to-back sweep of every decided word (R1..R5)
    prevW = '0;
    for (int w = 0; w < (1 << N); w++) begin
      @(negedge clk);
      if (w > 0) checkOut(prevW, 1'b1);
      driveWord(N'(w), w);
      validIn = 1'b1;
      prevW = N'(w);
    end
    @(negedge clk);
    checkOut(prevW, 1'b1);
    validIn = 1'b0;
    driveWord(12'h001, 1);
    @(negedge clk);
    checkOut(prevW, 1'b0);   // R6 hold after stream

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule